// File: doc/BRIEF.md
# Dual-Port Configuration Register Bank

This block holds the configuration bytes of an imaging analog front end. A host writes it through one of two write ports. One is a three-wire serial port: a serial clock, a data line and a commit enable. The other is an 8-bit parallel port with an active-low strobe, a line that marks the byte as address or data, and a read/write line. A static select input picks the active port. Every write carries a 6-bit address and an 8-bit data byte. The select input is meant to be tied off or changed only while both ports are idle.

The address space holds four setup registers and a software-reset location. It also holds seven groups of per-colour registers. Each group has a red, a green and a blue byte, and one sub-address code writes all three at once. The contents appear on parallel output fields. A one-cycle reset pulse is also given out, to be used by the logic that the registers control.

All port inputs pass through two-flop synchronisers into the system clock domain, and their edges are detected there. The system clock must therefore run at least four times faster than the serial clock, and every strobe level must last at least two system clock periods.

Top module: `cfg_regbank`

## Requirements
- R1: With `port_sel` low only the serial port can write. With `port_sel` high only the parallel port can write. Activity on the inactive port changes no register.
- R2: A serial frame is the last 14 bits shifted in before the commit: 6 address bits MSB first, then 8 data bits MSB first. Each bit is taken on a rising edge of `ser_clk`, and earlier extra bits are discarded.
- R3: Shifting serial bits writes nothing. A register changes only after a rising edge on `ser_en`, and each such edge produces exactly one write.
- R4: A parallel byte is captured while `par_stb_n` is low and acted on when it rises. With `par_is_data` low the byte's low 6 bits become the current address. With it high the byte is written to the most recently latched address.
- R5: A parallel byte presented with `par_rd` high is ignored. It neither writes a register nor replaces the latched address.
- R6: A parallel data byte that arrives before any address has been latched since hardware reset is ignored.
- R7: Address 01h writes `cfg_setup1`, 02h writes `cfg_setup2`, 03h writes `cfg_setup3` and 05h writes `cfg_setup4`. Writes to 00h, 06h–1Fh and 3Ch–3Fh change nothing.
- R8: Addresses whose bits [5:2] are 8 to 14 select the groups `dac_level`, `dac_sign`, `pga_gain`, `pix_offset`, `pix_gain_hi`, `pix_gain_lo` and `data_valid`, in that order. Bits [1:0] = 00 write red (field bits [7:0]), 01 write green ([15:8]) and 10 write blue ([23:16]).
- R9: Colour code 11 writes the same byte into the red, green and blue fields of the addressed group.
- R10: After hardware reset, `cfg_setup1` = 1Bh, `cfg_setup3` = 11h, every colour of `pix_gain_hi` = 80h and every colour of `data_valid` = 01h. All other registers are 00h.
- R11: A write to address 04h returns every register to its R10 default. It also raises `soft_rst` for exactly one system clock cycle. `soft_rst` is also high during hardware reset and for the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| port_sel | input | 1 | Port select: 1 parallel, 0 serial |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| ser_en | input | 1 | Serial commit enable, rising edge commits |
| par_byte | input | 8 | Parallel address or data byte |
| par_stb_n | input | 1 | Parallel strobe, active low |
| par_is_data | input | 1 | 0: byte is address, 1: byte is data |
| par_rd | input | 1 | Read/write line, writes need 0 |
| cfg_setup1 | output | 8 | Setup register 1 |
| cfg_setup2 | output | 8 | Setup register 2 |
| cfg_setup3 | output | 8 | Setup register 3 |
| cfg_setup4 | output | 8 | Setup register 4 |
| dac_level | output | 24 | DAC value per colour {blue, green, red} |
| dac_sign | output | 24 | DAC sign per colour |
| pga_gain | output | 24 | Amplifier gain per colour |
| pix_offset | output | 24 | Pixel offset per colour |
| pix_gain_hi | output | 24 | Pixel gain upper byte per colour |
| pix_gain_lo | output | 24 | Pixel gain lower byte per colour |
| data_valid | output | 24 | Data-valid byte per colour |
| soft_rst | output | 1 | One-cycle reset pulse |

## Verification
The assertions watch several rules on every cycle. The reset pulse never lasts longer than one cycle, and every pulse comes with the default values in place. A reserved-address write leaves the store untouched, and a broadcast leaves the three colours equal. Each commit from the serial port lasts one cycle and follows an enable edge. Neither a read-flagged byte nor an address-less data byte reaches the store. The inactive port never issues a write. The bench scenarios cover what only a full transaction can show: bit order, the discarding of extra leading bits, decoding into the right field and colour, a latched address reused by several data bytes, and a soft reset restoring every field.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 6;
    localparam int NUM_SETUP = 4;
    localparam int NUM_GRP   = 7;
    localparam int NUM_COL   = 3;
    localparam int GRP_W     = NUM_COL * BYTE_W;
    localparam int FRAME_W   = ADDR_W + BYTE_W;
    localparam int GI_W      = $clog2(NUM_GRP);
    localparam int SI_W      = $clog2(NUM_SETUP);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t      ADDR_SOFT_RST = 6'h04;
    localparam logic [3:0] GRP_BASE      = 4'h8;
    localparam logic [1:0] COL_ALL       = 2'b11;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        logic [NUM_SETUP-1:0][BYTE_W-1:0]              setup;
        logic [NUM_GRP-1:0][NUM_COL-1:0][BYTE_W-1:0]   grp;
        logic                                          pulse;
    } reg_state_t;

    // Setup register index for an address, -1 when not a setup location
    function automatic int setup_index(addr_t a);
        case (a)
            6'h01:   return 0;
            6'h02:   return 1;
            6'h03:   return 2;
            6'h05:   return 3;
            default: return -1;
        endcase
    endfunction

    function automatic byte_t setup_default(int i);
        case (i)
            0:       return 8'h1B;
            2:       return 8'h11;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t grp_default(int g);
        case (g)
            4:       return 8'h80;
            6:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic reg_state_t reg_defaults();
        reg_state_t s;
        for (int i = 0; i < NUM_SETUP; i++) s.setup[i] = setup_default(i);
        for (int g = 0; g < NUM_GRP; g++)
            for (int c = 0; c < NUM_COL; c++) s.grp[g][c] = grp_default(g);
        s.pulse = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/cfg_ser_rx.sv
module cfg_ser_rx
    import cfg_regbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    sclk,
    input  logic    sdat,
    input  logic    sen,
    output wr_req_t wr_o
);
    logic [2:0] s;
    logic       s_clk, s_dat, s_en;
    logic       clk_rise, en_rise;

    cfg_sync #(.W(3), .RST_VAL(3'b000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sdat, sen}),
        .q     (s)
    );

    assign {s_clk, s_dat, s_en} = s;

    typedef struct packed {
        logic               clk_prev;
        logic               en_prev;
        logic [FRAME_W-1:0] shreg;
        wr_req_t            wr;
    } ser_st_t;

    ser_st_t st_d, st_q;

    assign clk_rise = s_clk & ~st_q.clk_prev;
    assign en_rise  = s_en  & ~st_q.en_prev;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = s_clk;
        st_d.en_prev  = s_en;
        st_d.wr.valid = 1'b0;
        if (enable && clk_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], s_dat};
        end
        if (enable && en_rise) begin
            st_d.wr.valid = 1'b1;
            st_d.wr.addr  = st_q.shreg[FRAME_W-1 -: ADDR_W];
            st_d.wr.data  = st_q.shreg[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_o = st_q.wr;

    // R3: one write per enable edge, and only after the enable was seen high
    assert_commit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.valid |=> !st_q.wr.valid)
        else $error("serial commit longer than one cycle");
    assert_commit_after_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.valid |-> st_q.en_prev)
        else $error("serial commit without enable");
endmodule

// File: rtl/cfg_par_rx.sv
module cfg_par_rx
    import cfg_regbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  byte_t   pbyte,
    input  logic    stb_n,
    input  logic    is_data,
    input  logic    rd,
    output wr_req_t wr_o
);
    localparam int            SW       = BYTE_W + 3;
    localparam logic [SW-1:0] SYNC_RST = SW'(1) << BYTE_W;

    logic [SW-1:0] s;
    byte_t         s_byte;
    logic          s_stb, s_dat, s_rd;
    logic          stb_rise;

    cfg_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rd, is_data, stb_n, pbyte}),
        .q     (s)
    );

    assign {s_rd, s_dat, s_stb, s_byte} = s;

    typedef struct packed {
        logic    stb_prev;
        byte_t   cap_byte;
        logic    cap_dat;
        logic    cap_rd;
        addr_t   addr;
        logic    addr_ok;
        wr_req_t wr;
    } par_st_t;

    par_st_t st_d, st_q;

    assign stb_rise = s_stb & ~st_q.stb_prev;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = s_stb;
        st_d.wr.valid = 1'b0;
        if (!s_stb) begin
            st_d.cap_byte = s_byte;
            st_d.cap_dat  = s_dat;
            st_d.cap_rd   = s_rd;
        end
        if (enable && stb_rise && !st_q.cap_rd) begin
            if (!st_q.cap_dat) begin
                st_d.addr    = st_q.cap_byte[ADDR_W-1:0];
                st_d.addr_ok = 1'b1;
            end else if (st_q.addr_ok) begin
                st_d.wr.valid = 1'b1;
                st_d.wr.addr  = st_q.addr;
                st_d.wr.data  = st_q.cap_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stb_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_o = st_q.wr;

    assert_rd_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.valid |-> !st_q.cap_rd)
        else $error("parallel write issued with read line high");
    assert_data_needs_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.valid |-> st_q.addr_ok)
        else $error("parallel write before any address");
    assert_rd_keeps_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && st_q.cap_rd) |=> $stable(st_q.addr))
        else $error("read-flagged byte changed the address");
endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
    import cfg_regbank_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  wr_req_t                          wr_i,
    output logic [NUM_SETUP-1:0][BYTE_W-1:0] setup_o,
    output logic [NUM_GRP-1:0][GRP_W-1:0]    grp_o,
    output logic                             pulse_o
);
    localparam reg_state_t RST_STATE = reg_defaults();

    reg_state_t        st_d, st_q;
    int                sidx;
    logic              grp_hit;
    logic [3:0]        gsel;
    logic [GI_W-1:0]   gidx;
    logic [1:0]        csel;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        sidx       = setup_index(wr_i.addr);
        gsel       = wr_i.addr[ADDR_W-1:2];
        csel       = wr_i.addr[1:0];
        grp_hit    = (gsel >= GRP_BASE) && (gsel < GRP_BASE + 4'(NUM_GRP));
        gidx       = GI_W'(gsel - GRP_BASE);
        if (wr_i.valid) begin
            if (wr_i.addr == ADDR_SOFT_RST) begin
                st_d = RST_STATE;
            end else if (sidx >= 0) begin
                st_d.setup[SI_W'(sidx)] = wr_i.data;
            end else if (grp_hit) begin
                for (int c = 0; c < NUM_COL; c++) begin
                    if (csel == COL_ALL || csel == 2'(c))
                        st_d.grp[gidx][c] = wr_i.data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign setup_o = st_q.setup;
    assign pulse_o = st_q.pulse;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_out
        assign grp_o[g] = st_q.grp[g];

        // R9: a broadcast leaves the three colours of the group equal
        assert_broadcast_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i.valid && wr_i.addr == {GRP_BASE + 4'(g), COL_ALL})
            |=> (st_q.grp[g][0] == st_q.grp[g][1]) && (st_q.grp[g][1] == st_q.grp[g][2]))
            else $error("broadcast left colours unequal");
    end

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse)
        else $error("reset pulse longer than one cycle");
    assert_pulse_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> (st_q.setup[0] == 8'h1B) && (st_q.setup[1] == 8'h00)
                    && (st_q.setup[2] == 8'h11) && (st_q.grp[4][1] == 8'h80)
                    && (st_q.grp[6][2] == 8'h01) && (st_q.grp[0][0] == 8'h00))
        else $error("reset pulse without default contents");
    assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.valid && wr_i.addr == '0) |=> ($stable(st_q.setup) && $stable(st_q.grp)))
        else $error("reserved address changed the store");
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_sel,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_en,
    input  logic [BYTE_W-1:0]    par_byte,
    input  logic                 par_stb_n,
    input  logic                 par_is_data,
    input  logic                 par_rd,
    output logic [BYTE_W-1:0]    cfg_setup1,
    output logic [BYTE_W-1:0]    cfg_setup2,
    output logic [BYTE_W-1:0]    cfg_setup3,
    output logic [BYTE_W-1:0]    cfg_setup4,
    output logic [GRP_W-1:0]     dac_level,
    output logic [GRP_W-1:0]     dac_sign,
    output logic [GRP_W-1:0]     pga_gain,
    output logic [GRP_W-1:0]     pix_offset,
    output logic [GRP_W-1:0]     pix_gain_hi,
    output logic [GRP_W-1:0]     pix_gain_lo,
    output logic [GRP_W-1:0]     data_valid,
    output logic                 soft_rst
);
    wr_req_t                          ser_wr, par_wr, wr_sel;
    logic [NUM_SETUP-1:0][BYTE_W-1:0] setup;
    logic [NUM_GRP-1:0][GRP_W-1:0]    grp;

    cfg_ser_rx u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!port_sel),
        .sclk   (ser_clk),
        .sdat   (ser_dat),
        .sen    (ser_en),
        .wr_o   (ser_wr)
    );

    cfg_par_rx u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (port_sel),
        .pbyte   (par_byte),
        .stb_n   (par_stb_n),
        .is_data (par_is_data),
        .rd      (par_rd),
        .wr_o    (par_wr)
    );

    assign wr_sel = port_sel ? par_wr : ser_wr;

    cfg_reg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_sel),
        .setup_o (setup),
        .grp_o   (grp),
        .pulse_o (soft_rst)
    );

    assign cfg_setup1  = setup[0];
    assign cfg_setup2  = setup[1];
    assign cfg_setup3  = setup[2];
    assign cfg_setup4  = setup[3];
    assign dac_level   = grp[0];
    assign dac_sign    = grp[1];
    assign pga_gain    = grp[2];
    assign pix_offset  = grp[3];
    assign pix_gain_hi = grp[4];
    assign pix_gain_lo = grp[5];
    assign data_valid  = grp[6];

    // R1: the deselected port never issues a write
    assert_serial_muted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel && $stable(port_sel)) |-> !ser_wr.valid)
        else $error("serial write while parallel selected");
    assert_parallel_muted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_sel && $stable(port_sel)) |-> !par_wr.valid)
        else $error("parallel write while serial selected");
endmodule

// File: tb/tb_cfg_regbank.sv
module tb_cfg_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_sel = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
    logic [7:0]  par_byte = 8'h00;
    logic        par_stb_n = 1'b1, par_is_data = 1'b0, par_rd = 1'b0;
    logic [7:0]  cfg_setup1, cfg_setup2, cfg_setup3, cfg_setup4;
    logic [23:0] dac_level, dac_sign, pga_gain, pix_offset, pix_gain_hi, pix_gain_lo, data_valid;
    logic        soft_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_regbank dut (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .par_byte(par_byte), .par_stb_n(par_stb_n), .par_is_data(par_is_data), .par_rd(par_rd),
        .cfg_setup1(cfg_setup1), .cfg_setup2(cfg_setup2), .cfg_setup3(cfg_setup3), .cfg_setup4(cfg_setup4),
        .dac_level(dac_level), .dac_sign(dac_sign), .pga_gain(pga_gain), .pix_offset(pix_offset),
        .pix_gain_hi(pix_gain_hi), .pix_gain_lo(pix_gain_lo), .data_valid(data_valid),
        .soft_rst(soft_rst)
    );

    // Behavioural model
    logic [7:0] m_setup [4];
    logic [7:0] m_grp   [7][3];
    logic [5:0] m_addr;
    bit         m_addr_ok;
    int         exp_pulses, seen_pulses;
    int         errors, checks;
    bit         cmp_en, done;
    string      cur_req;

    function automatic void model_defaults();
        foreach (m_setup[i]) m_setup[i] = 8'h00;
        m_setup[0] = 8'h1B;
        m_setup[2] = 8'h11;
        foreach (m_grp[g, c]) m_grp[g][c] = (g == 4) ? 8'h80 : (g == 6) ? 8'h01 : 8'h00;
    endfunction

    function automatic void model_write(logic [5:0] a, logic [7:0] d);
        int g;
        if (a == 6'h04) begin
            model_defaults();
            exp_pulses++;
        end else if (a == 6'h01) m_setup[0] = d;
        else if (a == 6'h02) m_setup[1] = d;
        else if (a == 6'h03) m_setup[2] = d;
        else if (a == 6'h05) m_setup[3] = d;
        else if (a >= 6'h20 && a < 6'h3C) begin
            g = int'(a >> 2) - 8;
            for (int c = 0; c < 3; c++)
                if (a[1:0] == 2'b11 || int'(a[1:0]) == c) m_grp[g][c] = d;
        end
    endfunction

    function automatic logic [199:0] exp_vec();
        logic [199:0] v;
        v = {m_setup[3], m_setup[2], m_setup[1], m_setup[0], 168'h0};
        for (int g = 0; g < 7; g++)
            for (int c = 0; c < 3; c++) v[g*24 + c*8 +: 8] = m_grp[g][c];
        return v;
    endfunction

    wire [199:0] act_vec = {cfg_setup4, cfg_setup3, cfg_setup2, cfg_setup1,
                            data_valid, pix_gain_lo, pix_gain_hi, pix_offset,
                            pga_gain, dac_sign, dac_level};

    task automatic check(string req, logic [199:0] act, logic [199:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison whenever no transaction is in flight
    always @(negedge clk) begin
        if (rst_n && soft_rst) seen_pulses++;
        if (cmp_en && rst_n && !done) check(cur_req, act_vec, exp_vec());
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ser_bit(logic b);
        ser_dat = b; cyc(2);
        ser_clk = 1'b1; cyc(3);
        ser_clk = 1'b0; cyc(2);
    endtask

    task automatic ser_shift(logic [13:0] v, int n);
        for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
    endtask

    task automatic ser_write(logic [5:0] a, logic [7:0] d);
        cmp_en = 1'b0;
        ser_shift({a, d}, 14);
        ser_en = 1'b1; cyc(3);
        ser_en = 1'b0; cyc(7);
        if (!port_sel) model_write(a, d);
        cmp_en = 1'b1; cyc(3);
    endtask

    task automatic par_xfer(logic [7:0] b, logic is_d, logic rd);
        cmp_en = 1'b0;
        par_byte = b; par_is_data = is_d; par_rd = rd; cyc(2);
        par_stb_n = 1'b0; cyc(4);
        par_stb_n = 1'b1; cyc(6);
        if (port_sel && !rd) begin
            if (!is_d) begin m_addr = b[5:0]; m_addr_ok = 1'b1; end
            else if (m_addr_ok) model_write(m_addr, b);
        end
        cmp_en = 1'b1; cyc(3);
    endtask

    task automatic check_pulses(string req);
        check(req, 200'(seen_pulses), 200'(exp_pulses));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_defaults();
        m_addr_ok = 1'b0; m_addr = '0;
        exp_pulses = 1;             // hardware reset release (R11)
        cur_req = "R10";
        cyc(5);
        @(posedge clk); #1 rst_n = 1'b1;
        cmp_en = 1'b1; cyc(4);
        check_pulses("R11 hw reset pulse");

        // Serial port
        cur_req = "R2 R7 serial setup2"; ser_write(6'h02, 8'hA5);
        cur_req = "R3 shift without enable";
        ser_shift({6'h03, 8'h77}, 14); cyc(6);
        ser_write(6'h03, 8'h5A);
        cur_req = "R2 extra leading bits";
        cmp_en = 1'b0; ser_shift(14'h3, 2); ser_write(6'h05, 8'hC3);
        cur_req = "R8 serial red";   ser_write(6'h20, 8'h12);
        cur_req = "R8 serial green"; ser_write(6'h21, 8'h34);
        cur_req = "R8 serial blue";  ser_write(6'h22, 8'h56);
        cur_req = "R8 gain lsb blue"; ser_write(6'h36, 8'h9E);
        cur_req = "R9 serial broadcast"; ser_write(6'h2B, 8'hE7);
        cur_req = "R7 reserved"; ser_write(6'h00, 8'hFF);
        cur_req = "R7 unmapped high"; ser_write(6'h3D, 8'hFF);
        cur_req = "R7 unmapped low";  ser_write(6'h06, 8'hFF);
        cur_req = "R1 parallel idle in serial mode";
        par_xfer(8'h01, 1'b0, 1'b0); par_xfer(8'hEE, 1'b1, 1'b0);

        // Parallel port
        port_sel = 1'b1; cyc(4);
        cur_req = "R1 serial ignored in parallel mode"; ser_write(6'h01, 8'h99);
        cur_req = "R6 data before address"; par_xfer(8'h42, 1'b1, 1'b0);
        cur_req = "R4 parallel green"; par_xfer(8'h21, 1'b0, 1'b0); par_xfer(8'h3C, 1'b1, 1'b0);
        cur_req = "R4 reuse latched address"; par_xfer(8'h44, 1'b1, 1'b0);
        cur_req = "R5 read-flagged address"; par_xfer(8'h01, 1'b0, 1'b1);
        cur_req = "R5 read-flagged data";    par_xfer(8'h66, 1'b1, 1'b1);
        cur_req = "R5 address kept"; par_xfer(8'h55, 1'b1, 1'b0);
        cur_req = "R9 parallel broadcast"; par_xfer(8'hEF, 1'b0, 1'b0); par_xfer(8'h3A, 1'b1, 1'b0);
        cur_req = "R7 parallel setup4"; par_xfer(8'h05, 1'b0, 1'b0); par_xfer(8'h81, 1'b1, 1'b0);
        cur_req = "R8 parallel dac sign red"; par_xfer(8'h24, 1'b0, 1'b0); par_xfer(8'h07, 1'b1, 1'b0);
        check_pulses("R11 no pulse before soft reset");
        cur_req = "R11 soft reset"; par_xfer(8'h04, 1'b0, 1'b0); par_xfer(8'h00, 1'b1, 1'b0);
        check_pulses("R11 one soft pulse");
        cur_req = "R4 write after soft reset"; par_xfer(8'h01, 1'b0, 1'b0); par_xfer(8'h6C, 1'b1, 1'b0);

        cyc(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule